// File: doc/BRIEF.md
# Paged Serial-Flash Command Front End

This block is the slave side of a serial command interface for a paged flash-style memory. While the chip select is low, it collects an 8-bit command code from the serial input. It then collects a 24-bit address. The address is split either into a page number plus a byte offset, or into a single byte offset into an internal page buffer. The buffer holds 264 bytes: 256 data bytes and 8 spare bytes. Eight such pages form a 2112-byte block in the array behind this block. Because 264 is not a power of two, byte offsets take 9 bits and need explicit wrap and range handling.

The block does three jobs. It streams bytes out of the page buffer and writes streamed bytes into it. It also hands a page-fetch request to a separate main-array controller. That request is a one-cycle strobe issued when chip select returns high, and it carries the captured page number. There are two buffer-read commands. One drives output bits on falling SCK edges, for SPI mode 0 or 3 hosts. The other drives output bits on rising SCK edges, for inactive-clock-polarity hosts. The choice of command also moves the cycle on which the first output bit appears.

SCK, chip select and serial input are sampled by the system clock `clk`. The host's serial clock must therefore run well below `clk`, with each SCK level held for at least two `clk` periods.

Top module: `pflash_front`

## Requirements
- R1: A frame starts only when csN falls; that edge discards any partial state of an earlier frame. The first 8 bits shifted in on rising SCK edges, MSB first, form the command code.
- R2: The 24-bit address follows the command code, MSB first. Bits [18:9] are the page number, bits [8:0] are the byte offset, and bits [23:19] are ignored.
- R3: Command 0x84 writes the buffer. After the address, every 8 bits (MSB first) form a byte that is stored at the current offset. A byte left incomplete when csN rises is discarded.
- R4: Command 0xD4 reads the buffer with SPI-mode timing. The first bit (bit 7 of the addressed byte) is driven on so after the falling SCK edge that follows the 32nd rising edge. Later bits change on each falling edge.
- R5: Command 0x54 reads the buffer with inactive-clock-polarity timing. The first bit is driven after the 33rd rising SCK edge. Later bits change on each rising edge.
- R6: During a continuous read or write, the byte offset advances by one after each byte and wraps from 263 to 0.
- R7: A starting byte offset in the range 264 to 511 is taken as the offset minus 264.
- R8: soOe is 0 whenever csN is high and during the command and address bits. It is 1 during the data phase of a read command.
- R9: Any command code other than 0x54, 0xD4, 0x84 and 0x53 causes the rest of the frame to be ignored. No buffer byte changes and soOe stays 0.
- R10: For command 0x53, a rising csN after all 32 command and address bits makes xferReq 1 for exactly one clk cycle, with pageAddr holding the page number. A frame cut short before the 32nd bit raises no request and leaves pageAddr unchanged.
- R11: After reset, soOe, xferReq and pageAddr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all serial inputs |
| rstN | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out; valid only while soOe is 1 |
| soOe | output | 1 | Output enable for so; 0 means high impedance |
| pageAddr | output | 10 | Page number captured by the last page-transfer command |
| xferReq | output | 1 | One-cycle request to the main-array controller |

## Verification
Each SCK or csN edge is seen at the first rising `clk` edge after it changes. so therefore settles one `clk` cycle after the SCK edge that drives it. xferReq is high during the single cycle that follows the `clk` edge which sees csN rise. The bench holds every SCK level for four `clk` cycles. For SPI-mode reads it samples so just before each rising SCK edge. For inactive-polarity reads it samples so at the end of each high phase. Around the csN rise it samples xferReq at the next two falling `clk` edges, which confirms both that the pulse is present and that it lasts one cycle.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

  localparam logic [7:0] OpRdIcp = 8'h54;
  localparam logic [7:0] OpRdSpi = 8'hD4;
  localparam logic [7:0] OpWrBuf = 8'h84;
  localparam logic [7:0] OpXfer  = 8'h53;

  typedef enum logic [2:0] {
    PhIdle,
    PhOpc,
    PhAddr,
    PhData,
    PhArmed,
    PhSkip
  } phase_t;

  typedef struct packed {
    logic shiftIn;
    logic loadAddr;
    logic loadPage;
    logic shiftData;
    logic writeByte;
    logic loadOut;
    logic shiftOut;
  } ctl_t;

endpackage

// File: rtl/pflash_ctrl.sv
module pflash_ctrl
  import pflash_pkg::*;
#(
  parameter int CmdBits   = 8,
  parameter int FrameBits = 24
) (
  input  logic clk,
  input  logic rstN,
  input  logic sck,
  input  logic csN,
  input  logic si,
  output ctl_t ctl,
  output logic soOe,
  output logic xferReq
);

  localparam int CntW = $clog2(FrameBits);

  logic            sckQ;
  logic            csQ;
  logic [CntW-1:0] bitCnt;
  logic [CmdBits-2:0] opShift;
  logic [CmdBits-1:0] opcode;
  logic [CmdBits-1:0] newOp;
  logic [2:0]      bitInByte;
  logic            spiMode;
  phase_t          phase;

  logic sckRise, sckFall, csFall, csRise, isRead, outEdge, knownOp;

  assign sckRise = sck & ~sckQ & ~csN;
  assign sckFall = ~sck & sckQ & ~csN;
  assign csFall  = ~csN & csQ;
  assign csRise  = csN & ~csQ;
  assign isRead  = (opcode == OpRdIcp) || (opcode == OpRdSpi);
  assign outEdge = spiMode ? sckFall : sckRise;
  assign newOp   = {opShift, si};
  assign knownOp = (newOp == OpRdIcp) || (newOp == OpRdSpi) ||
                   (newOp == OpWrBuf) || (newOp == OpXfer);

  assign soOe = ~csN && (phase == PhData) && isRead;

  always_comb begin
    ctl = '0;
    if (phase == PhAddr && sckRise) begin
      ctl.shiftIn = 1'b1;
      if (bitCnt == CntW'(FrameBits - 1)) begin
        ctl.loadAddr = 1'b1;
        ctl.loadPage = (opcode == OpXfer);
      end
    end
    if (phase == PhData) begin
      if (opcode == OpWrBuf && sckRise) begin
        ctl.shiftData = 1'b1;
        ctl.writeByte = (bitInByte == 3'd7);
      end
      if (isRead && outEdge) begin
        ctl.loadOut  = (bitInByte == 3'd0);
        ctl.shiftOut = (bitInByte != 3'd0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckQ      <= 1'b0;
      csQ       <= 1'b1;
      bitCnt    <= '0;
      opShift   <= '0;
      opcode    <= '0;
      bitInByte <= '0;
      spiMode   <= 1'b0;
      phase     <= PhIdle;
      xferReq   <= 1'b0;
    end else begin
      sckQ    <= sck;
      csQ     <= csN;
      xferReq <= csRise && (phase == PhArmed);
      if (csN) begin
        phase <= PhIdle;
      end else if (csFall) begin
        phase     <= PhOpc;
        bitCnt    <= '0;
        bitInByte <= '0;
      end else begin
        case (phase)
          PhOpc: if (sckRise) begin
            opShift <= newOp[CmdBits-2:0];
            bitCnt  <= bitCnt + 1'b1;
            if (bitCnt == CntW'(CmdBits - 1)) begin
              opcode <= newOp;
              bitCnt <= '0;
              phase  <= knownOp ? PhAddr : PhSkip;
              if (newOp == OpRdSpi) spiMode <= 1'b1;
              if (newOp == OpRdIcp) spiMode <= 1'b0;
            end
          end
          PhAddr: if (sckRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == CntW'(FrameBits - 1)) begin
              phase     <= (opcode == OpXfer) ? PhArmed : PhData;
              bitInByte <= '0;
            end
          end
          PhData: if (ctl.shiftData || ctl.loadOut || ctl.shiftOut)
            bitInByte <= bitInByte + 1'b1;
          default: ;
        endcase
      end
    end
  end

  AST_SO_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !soOe); // R8
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    xferReq |=> !xferReq); // R10
  AST_REQ_AFTER_RISE: assert property (@(posedge clk) disable iff (!rstN)
    xferReq |-> csN); // R10

endmodule

// File: rtl/pflash_dpath.sv
module pflash_dpath
  import pflash_pkg::*;
#(
  parameter int PageBytes = 264,
  parameter int AddrW     = 9,
  parameter int PageW     = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             si,
  input  ctl_t             ctl,
  output logic             so,
  output logic [PageW-1:0] pageAddr
);

  localparam int FieldW = AddrW + PageW;
  localparam logic [AddrW-1:0] LastAddr = AddrW'(PageBytes - 1);
  localparam logic [AddrW-1:0] PageSize = AddrW'(PageBytes);

  logic [FieldW-2:0] inShift;
  logic [FieldW-1:0] frame;
  logic [AddrW-1:0]  rawAddr;
  logic [AddrW-1:0]  startAddr;
  logic [AddrW-1:0]  byteAddr;
  logic [AddrW-1:0]  nextAddr;
  logic [6:0]        dataShift;
  logic [6:0]        outByte;
  logic [7:0]        rdByte;
  logic              soBit;
  logic [PageW-1:0]  pageReg;
  logic [7:0]        mem [PageBytes];

  assign frame     = {inShift, si};
  assign rawAddr   = frame[AddrW-1:0];
  assign startAddr = (rawAddr >= PageSize) ? rawAddr - PageSize : rawAddr;
  assign nextAddr  = (byteAddr == LastAddr) ? '0 : byteAddr + 1'b1;
  assign rdByte    = mem[byteAddr];
  assign so        = soBit;
  assign pageAddr  = pageReg;

  always_ff @(posedge clk) begin
    if (ctl.writeByte) mem[byteAddr] <= {dataShift, si};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inShift   <= '0;
      byteAddr  <= '0;
      pageReg   <= '0;
      dataShift <= '0;
      outByte   <= '0;
      soBit     <= 1'b0;
    end else begin
      if (ctl.shiftIn)   inShift <= frame[FieldW-2:0];
      if (ctl.loadAddr)  byteAddr <= startAddr;
      if (ctl.loadPage)  pageReg <= frame[FieldW-1:AddrW];
      if (ctl.shiftData) dataShift <= {dataShift[5:0], si};
      if (ctl.writeByte) byteAddr <= nextAddr;
      if (ctl.loadOut) begin
        soBit    <= rdByte[7];
        outByte  <= rdByte[6:0];
        byteAddr <= nextAddr;
      end
      if (ctl.shiftOut) begin
        soBit   <= outByte[6];
        outByte <= {outByte[5:0], 1'b0};
      end
    end
  end

  AST_ADDR_IN_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    byteAddr < PageSize); // R7
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.writeByte || ctl.loadOut) && byteAddr == LastAddr |=> byteAddr == '0); // R6

endmodule

// File: rtl/pflash_front.sv
module pflash_front
  import pflash_pkg::*;
#(
  parameter int PageBytes = 264,
  parameter int PageW     = 10,
  parameter int FrameBits = 24,
  parameter int CmdBits   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sck,
  input  logic             csN,
  input  logic             si,
  output logic             so,
  output logic             soOe,
  output logic [PageW-1:0] pageAddr,
  output logic             xferReq
);

  localparam int AddrW = $clog2(PageBytes);

  ctl_t ctl;

  pflash_ctrl #(
    .CmdBits  (CmdBits),
    .FrameBits(FrameBits)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .sck    (sck),
    .csN    (csN),
    .si     (si),
    .ctl    (ctl),
    .soOe   (soOe),
    .xferReq(xferReq)
  );

  pflash_dpath #(
    .PageBytes(PageBytes),
    .AddrW    (AddrW),
    .PageW    (PageW)
  ) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .si      (si),
    .ctl     (ctl),
    .so      (so),
    .pageAddr(pageAddr)
  );

endmodule

// File: tb/sim_pflash_front.sv
module sim_pflash_front;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sck = 1'b0;
  logic       csN = 1'b1;
  logic       si = 1'b0;
  logic       so;
  logic       soOe;
  logic [9:0] pageAddr;
  logic       xferReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit oeSeen = 1'b0;

  always #10 clk = ~clk;

  pflash_front u0 (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .si(si),
    .so(so), .soOe(soOe), .pageAddr(pageAddr), .xferReq(xferReq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitIO(input logic b, output logic preRise, output logic postRise);
    si = b;
    tick(4);
    preRise = so;
    if (soOe) oeSeen = 1'b1;
    sck = 1'b1;
    tick(4);
    postRise = so;
    sck = 1'b0;
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    logic a, b;
    for (int i = n - 1; i >= 0; i--) bitIO(v[i], a, b);
  endtask

  task automatic startFrame();
    csN = 1'b0;
    oeSeen = 1'b0;
    tick(2);
  endtask

  task automatic endFrame();
    tick(2);
    csN = 1'b1;
    tick(2);
  endtask

  task automatic readByte(input bit spi, output logic [7:0] v);
    logic a, b;
    for (int i = 7; i >= 0; i--) begin
      bitIO(1'b0, a, b);
      v[i] = spi ? a : b;
    end
  endtask

  task automatic writeBuf(input int addr, input logic [7:0] d0, input int n,
                          input logic [7:0] d1, input logic [7:0] d2);
    startFrame();
    sendBits({8'h84, 24'(addr)}, 32);
    sendBits({24'd0, d0}, 8);
    if (n > 1) sendBits({24'd0, d1}, 8);
    if (n > 2) sendBits({24'd0, d2}, 8);
    endFrame();
  endtask

  task automatic readOne(input bit spi, input int addr, output logic [7:0] v);
    startFrame();
    sendBits({spi ? 8'hD4 : 8'h54, 24'(addr)}, 32);
    check(!oeSeen, "R8 oe during cmd/addr", oeSeen, 0);
    readByte(spi, v);
    check(oeSeen, "R8 oe during read data", oeSeen, 1);
    endFrame();
    check(!soOe, "R8 oe after frame", soOe, 0);
  endtask

  task automatic testReset();
    check(soOe == 1'b0, "R11 soOe", soOe, 0);
    check(xferReq == 1'b0, "R11 xferReq", xferReq, 0);
    check(pageAddr == 10'd0, "R11 pageAddr", pageAddr, 0);
  endtask

  task automatic testWriteReadSpi();
    logic [7:0] v;
    writeBuf(10, 8'hA5, 3, 8'h3C, 8'hF0);
    startFrame();
    sendBits({8'hD4, 24'd10}, 32);
    readByte(1'b1, v); check(v == 8'hA5, "R4 spi byte0", v, 8'hA5);
    readByte(1'b1, v); check(v == 8'h3C, "R3 R4 spi byte1", v, 8'h3C);
    readByte(1'b1, v); check(v == 8'hF0, "R3 R4 spi byte2", v, 8'hF0);
    endFrame();
  endtask

  task automatic testReadIcp();
    logic [7:0] v;
    startFrame();
    sendBits({8'h54, 24'd10}, 32);
    readByte(1'b0, v); check(v == 8'hA5, "R5 icp byte0", v, 8'hA5);
    readByte(1'b0, v); check(v == 8'h3C, "R5 icp byte1", v, 8'h3C);
    endFrame();
  endtask

  task automatic testWrap();
    logic [7:0] v;
    writeBuf(262, 8'h11, 3, 8'h22, 8'h33);
    startFrame();
    sendBits({8'hD4, 24'd262}, 32);
    readByte(1'b1, v); check(v == 8'h11, "R6 byte262", v, 8'h11);
    readByte(1'b1, v); check(v == 8'h22, "R6 byte263", v, 8'h22);
    readByte(1'b1, v); check(v == 8'h33, "R6 wrap to 0", v, 8'h33);
    endFrame();
    readOne(1'b0, 0, v);
    check(v == 8'h33, "R6 written byte0", v, 8'h33);
  endtask

  task automatic testHighOffset();
    logic [7:0] v;
    writeBuf(284, 8'h77, 1, 8'h00, 8'h00);
    readOne(1'b1, 20, v);
    check(v == 8'h77, "R7 offset 284 maps to 20", v, 8'h77);
    readOne(1'b1, 32'hF8_0000 | 20, v);
    check(v == 8'h77, "R2 pad bits ignored", v, 8'h77);
  endtask

  task automatic testPartial();
    logic [7:0] v;
    writeBuf(31, 8'h00, 1, 8'h00, 8'h00);
    startFrame();
    sendBits({8'h84, 24'd30}, 32);
    sendBits(32'h9A, 8);
    sendBits(32'h1F, 5);
    endFrame();
    readOne(1'b1, 30, v); check(v == 8'h9A, "R3 full byte kept", v, 8'h9A);
    readOne(1'b1, 31, v); check(v == 8'h00, "R3 partial byte dropped", v, 8'h00);
  endtask

  task automatic testUnknown();
    logic [7:0] v;
    startFrame();
    sendBits({8'h55, 24'd30}, 32);
    sendBits(32'hFF, 8);
    sendBits(32'hFF, 8);
    check(!oeSeen, "R9 R8 oe stays 0 on unknown", oeSeen, 0);
    endFrame();
    readOne(1'b1, 30, v); check(v == 8'h9A, "R9 buffer untouched", v, 8'h9A);
  endtask

  task automatic testRestart();
    logic [7:0] v;
    startFrame();
    sendBits(32'h1B, 5);
    csN = 1'b1;
    tick(4);
    readOne(1'b0, 10, v);
    check(v == 8'hA5, "R1 new frame after partial", v, 8'hA5);
  endtask

  task automatic testXfer();
    startFrame();
    sendBits({8'h53, 5'b10101, 10'h2B5, 9'h01F}, 32);
    tick(2);
    csN = 1'b1;
    @(negedge clk);
    check(xferReq == 1'b1, "R10 request raised", xferReq, 1);
    check(pageAddr == 10'h2B5, "R10 R2 page field", pageAddr, 10'h2B5);
    @(negedge clk);
    check(xferReq == 1'b0, "R10 request one cycle", xferReq, 0);
    tick(4);
    startFrame();
    sendBits({8'h53, 20'h00ABC}, 28);
    tick(2);
    csN = 1'b1;
    @(negedge clk);
    check(xferReq == 1'b0, "R10 short frame no request", xferReq, 0);
    @(negedge clk);
    check(xferReq == 1'b0, "R10 short frame no request late", xferReq, 0);
    check(pageAddr == 10'h2B5, "R10 page kept", pageAddr, 10'h2B5);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(2);
    testReset();
    testWriteReadSpi();
    testReadIcp();
    testWrap();
    testHighOffset();
    testPartial();
    testUnknown();
    testRestart();
    testXfer();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule